// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer

This block is an 8-bit timer that counts up from zero to its top value and back down again. It compares the count with a compare value and drives a pulse-width-modulated pin whose pulses are centred on the bottom of each triangle. A selectable divider produces a one-cycle enable pulse, so the counter advances once every N system clocks and the whole block runs on a single clock. The compare value is written through a simple strobe into a holding register. That register moves into the active comparator only when the count reaches the top, so a write never splits a period.

The pin level is worked out from the count, the direction and the active compare value, not from toggles on an exact equality. Extreme compare values therefore give steady levels. When a new compare value leaves the count on the wrong side of it, the pin still switches at once, without waiting for a match. Two sticky flags mark the count reaching zero and the tick after a compare match. Each flag is cleared by its own strobe.

Top module: `pwm_phase_timer`

## Requirements
- R1: `clk_sel` picks the step rate: code 1 gives a step every clock, and codes 2, 3, 4, 5, 6 and 7 give a step every 8, 32, 64, 128, 256 and 1024 clocks.
- R2: With `clk_sel` = 0 or `en` = 0 the count and the pin hold their values. Any change of `clk_sel` restarts the divider, so the first step comes N+1 clocks after the new code is applied.
- R3: The count steps 0,1,…,255 and then 254,…,0, turning at 255 and at 0. Returns to zero are 510 steps apart, so the pin period is N×510 clocks.
- R4: With non-inverted polarity the pin falls where the rising count meets the compare value and rises where the falling count meets it. Over any 510 consecutive steps the pin is high for 2×C steps, where C is the active compare value (0 < C < 255).
- R5: An active compare value of 0 holds the non-inverted pin low, and a value of 255 holds it high.
- R6: When the count sits at 255 the pin shows the level the rising-count compare would give. A change of the compare value away from 255 therefore drops the pin on the step that brings the count to 255.
- R7: `cmp_wr` stores `cmp_wdata` in a holding register. That value becomes active only on the step that brings the count to 255, and the pin keeps following the previous value until then.
- R8: `ovf_flag` is set on the step that brings the count to 0. It stays set until `ovf_flag_clr` is pulsed, and setting wins over clearing in the same cycle.
- R9: `cmp_flag` is set on the first step taken while the count equals the active compare value. It stays set until `cmp_flag_clr` is pulsed.
- R10: `invert` = 1 drives the pin to the complement of its non-inverted level, and it takes effect at once, even while the counter is stopped.
- R11: After reset the count is 0 and rising, the active and held compare values are 0, both flags are 0, and the pin equals `invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global run enable |
| clk_sel | input | 3 | Divider code (0 stops the counter) |
| invert | input | 1 | Output polarity (1 = inverted) |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to store |
| cmp_flag_clr | input | 1 | Clears the compare flag |
| ovf_flag_clr | input | 1 | Clears the overflow flag |
| pwm_out | output | 1 | PWM pin level |
| count | output | 8 | Current count |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky bottom-reached flag |

## Verification
The bench builds the block with its default 8-bit count and 10-bit divider. At divide-by-one a full 510-step period lasts only 510 clocks, so it can measure the high time of many compare and polarity pairs exactly, including 0, 1, 254 and 255. The same defaults let it time every divider code, the largest included, and the restart after a code change. Directed runs then catch the compare load at the top, the forced fall when the value leaves 255, and the cycle-exact setting of each flag.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;
  localparam int CNT_W = 8;
  localparam int PS_W  = 10;

  typedef enum logic [2:0] {
    CS_STOP, CS_DIV1, CS_DIV8, CS_DIV32,
    CS_DIV64, CS_DIV128, CS_DIV256, CS_DIV1024
  } clk_sel_e;

  // last divider count value before a step (N - 1)
  function automatic logic [PS_W-1:0] div_limit(input clk_sel_e s);
    case (s)
      CS_DIV8:    return PS_W'(7);
      CS_DIV32:   return PS_W'(31);
      CS_DIV64:   return PS_W'(63);
      CS_DIV128:  return PS_W'(127);
      CS_DIV256:  return PS_W'(255);
      CS_DIV1024: return PS_W'(1023);
      default:    return PS_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pc_pkg::*;
#(
  parameter int PW = PS_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] ps_q;
  logic [2:0]    sel_q;
  logic          run;
  logic [PW-1:0] lim;

  assign lim  = PW'(div_limit(clk_sel_e'(sel)));
  assign run  = en && (sel != 3'd0) && (sel == sel_q);
  assign tick = run && (ps_q == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q  <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      if (!run || tick) ps_q <= '0;
      else              ps_q <= ps_q + 1'b1;
    end
  end

  // R2
  tick_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |-> !tick);
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         up_nxt
);
  localparam logic [W-1:0] MAXV = '1;
  logic up_q;

  always_comb begin
    cnt_nxt = cnt_q;
    up_nxt  = up_q;
    if (tick) begin
      if (cnt_q == MAXV)      begin cnt_nxt = MAXV - 1'b1; up_nxt = 1'b0; end
      else if (cnt_q == '0)   begin cnt_nxt = W'(1);       up_nxt = 1'b1; end
      else if (up_q)          cnt_nxt = cnt_q + 1'b1;
      else                    cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R3
  cnt_up_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && up_q && cnt_q != MAXV) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R3
  cnt_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == MAXV) |=> (cnt_q == MAXV - 1'b1 && !up_q));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_nxt,
  input  logic         up_nxt,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ocr_act,
  output logic         raw_q
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] ocr_buf, ocr_nxt;
  logic         at_top;

  // level the non-inverted pin takes for a given count, phase and compare
  function automatic logic wave_level(input logic [W-1:0] c,
                                      input logic up,
                                      input logic [W-1:0] ocr);
    if (ocr == '0)   return 1'b0;
    if (ocr == MAXV) return 1'b1;
    return up ? (c < ocr) : (c <= ocr);
  endfunction

  assign at_top  = tick && (cnt_nxt == MAXV);
  assign ocr_nxt = at_top ? ocr_buf : ocr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr) ocr_buf <= wdata;
      ocr_act <= ocr_nxt;
      if (tick) raw_q <= wave_level(cnt_nxt, up_nxt, ocr_nxt);
    end
  end

  // R7
  act_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ocr_act) |-> (cnt_q == MAXV));
  // R5
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ocr_act == '0) |-> !raw_q);
  // R5
  high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ocr_act == MAXV) |-> raw_q);
endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] ocr_act,
  input  logic         cmp_clr,
  input  logic         ovf_clr,
  output logic         cmp_q,
  output logic         ovf_q
);
  logic cmp_set, ovf_set;

  assign cmp_set = tick && (cnt_q == ocr_act);
  assign ovf_set = tick && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cmp_set)      cmp_q <= 1'b1;
      else if (cmp_clr) cmp_q <= 1'b0;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> (cnt_q == '0));
  // R9
  cmp_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_q) |-> ($past(cnt_q) == $past(ocr_act)));
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_pc_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int PW = PS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   clk_sel,
  input  logic         invert,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cmp_flag_clr,
  input  logic         ovf_flag_clr,
  output logic         pwm_out,
  output logic [W-1:0] count,
  output logic         cmp_flag,
  output logic         ovf_flag
);
  logic         tick, up_nxt, raw_q;
  logic [W-1:0] cnt_q, cnt_nxt, ocr_act;

  pwm_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .en(en), .sel(clk_sel), .tick(tick));

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .up_nxt(up_nxt));

  pwm_wave #(.W(W)) u_wave (
    .clk(clk), .rst(rst), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .up_nxt(up_nxt), .wr(cmp_wr), .wdata(cmp_wdata),
    .ocr_act(ocr_act), .raw_q(raw_q));

  pwm_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .ocr_act(ocr_act), .cmp_clr(cmp_flag_clr), .ovf_clr(ovf_flag_clr),
    .cmp_q(cmp_flag), .ovf_q(ovf_flag));

  assign pwm_out = raw_q ^ invert;
  assign count   = cnt_q;

  // R10
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (invert != $past(invert) && !$past(tick)) |-> (pwm_out != $past(pwm_out)));
endmodule

// File: tb/pwm_phase_timer_bench.sv
module pwm_phase_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {compare, invert, expected high steps over 510}
  localparam logic [7:0]  V_OCR [NV] = '{8'd0, 8'd255, 8'd1, 8'd254, 8'd100, 8'd128,
                                         8'd0, 8'd255, 8'd100, 8'd50, 8'd200};
  localparam logic        V_INV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_HI  [NV] = '{0, 510, 2, 508, 200, 256,
                                         510, 0, 310, 100, 110};

  logic clk = 0, rst = 1, en = 0, invert = 0, cmp_wr = 0;
  logic cmp_flag_clr = 0, ovf_flag_clr = 0;
  logic [2:0] clk_sel = 0;
  logic [7:0] cmp_wdata = 0;
  logic pwm_out, cmp_flag, ovf_flag;
  logic [7:0] count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_timer u_pwm_phase_timer (
    .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel), .invert(invert),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_flag_clr(cmp_flag_clr),
    .ovf_flag_clr(ovf_flag_clr), .pwm_out(pwm_out), .count(count),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (count != 8'(v));
  endtask

  task automatic write_cmp(input int v);
    cmp_wdata = 8'(v); cmp_wr = 1;
    @(negedge clk); cmp_wr = 0;
  endtask

  // write, then wait until the value is active (count just reached 255)
  task automatic load_cmp(input int v);
    write_cmp(v);
    wait_cnt(128);
    wait_cnt(255);
  endtask

  // cycles from now until the count next changes
  task automatic gap(output int n);
    logic [7:0] prev;
    prev = count; n = 0;
    do begin @(negedge clk); n++; end while (count == prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, n;
    logic [7:0] held_c;
    logic held_o;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(count == 0, "R11 count", count, 0);
    check(pwm_out == 0, "R11 pin", pwm_out, 0);
    check(!cmp_flag && !ovf_flag, "R11 flags", {cmp_flag, ovf_flag}, 0);

    // R2 stopped by code 0 and by en
    en = 1; repeat (20) @(negedge clk);
    check(count == 0, "R2 sel0 hold", count, 0);
    en = 0; clk_sel = 1; repeat (20) @(negedge clk);
    check(count == 0, "R2 en hold", count, 0);
    en = 1;

    // R4 R5 R10 duty table at divide-by-one
    for (int i = 0; i < NV; i++) begin
      invert = V_INV[i];
      load_cmp(V_OCR[i]);
      hi = 0;
      for (int k = 0; k < 510; k++) begin
        if (pwm_out) hi++;
        @(negedge clk);
      end
      check(hi == V_HI[i], $sformatf("R4/R5/R10 vec%0d", i), hi, V_HI[i]);
    end
    invert = 0;

    // R3 period and turnaround
    wait_cnt(0); n = 0;
    do begin @(negedge clk); n++; end while (count != 0);
    check(n == 510, "R3 period", n, 510);
    wait_cnt(254); @(negedge clk);
    check(count == 255, "R3 top", count, 255);
    @(negedge clk);
    check(count == 254, "R3 turn", count, 254);

    // R7 buffered compare
    load_cmp(100);
    wait_cnt(0); wait_cnt(50);
    write_cmp(10);
    wait_cnt(60);
    check(pwm_out == 1, "R7 old value kept", pwm_out, 1);
    wait_cnt(255); wait_cnt(60);
    check(pwm_out == 0, "R7 new value active", pwm_out, 0);

    // R6 leaving 255 drops the pin at the top
    load_cmp(255);
    write_cmp(100);
    wait_cnt(0); wait_cnt(254);
    check(pwm_out == 1, "R6 before top", pwm_out, 1);
    @(negedge clk);
    check(count == 255 && pwm_out == 0, "R6 fall at top", pwm_out, 0);

    // R9 compare flag (active value 100)
    wait_cnt(0); wait_cnt(90);
    cmp_flag_clr = 1; @(negedge clk); cmp_flag_clr = 0;
    wait_cnt(100);
    check(cmp_flag == 0, "R9 not yet", cmp_flag, 0);
    @(negedge clk);
    check(count == 101 && cmp_flag == 1, "R9 set after match", cmp_flag, 1);
    cmp_flag_clr = 1; @(negedge clk); cmp_flag_clr = 0;
    check(cmp_flag == 0, "R9 cleared", cmp_flag, 0);

    // R8 overflow flag
    wait_cnt(150);
    ovf_flag_clr = 1; @(negedge clk); ovf_flag_clr = 0;
    wait_cnt(255); wait_cnt(1);
    check(ovf_flag == 0, "R8 not yet", ovf_flag, 0);
    @(negedge clk);
    check(count == 0 && ovf_flag == 1, "R8 set at zero", ovf_flag, 1);
    repeat (5) @(negedge clk);
    check(ovf_flag == 1, "R8 sticky", ovf_flag, 1);
    ovf_flag_clr = 1; @(negedge clk); ovf_flag_clr = 0;
    check(ovf_flag == 0, "R8 cleared", ovf_flag, 0);

    // R2 stop holds count and pin; R10 polarity while stopped
    wait_cnt(30);
    clk_sel = 0; @(negedge clk);
    held_c = count; held_o = pwm_out;
    repeat (30) @(negedge clk);
    check(count == held_c && pwm_out == held_o, "R2 stop hold", count, held_c);
    invert = 1; #1;
    check(pwm_out == !held_o, "R10 invert while stopped", pwm_out, !held_o);
    invert = 0;

    // R1 divider codes
    for (int s = 2; s < 8; s++) begin
      int expn;
      case (s)
        2: expn = 8;   3: expn = 32;  4: expn = 64;
        5: expn = 128; 6: expn = 256; default: expn = 1024;
      endcase
      clk_sel = 3'(s);
      gap(n); gap(n);
      check(n == expn, $sformatf("R1 code%0d", s), n, expn);
    end

    // R2 code change restarts the divider
    clk_sel = 2; gap(n); gap(n);
    repeat (3) @(negedge clk);
    clk_sel = 3;
    gap(n);
    check(n == 33, "R2 restart", n, 33);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule